// File: doc/BRIEF.md
# CAN Transmit Slot Scheduler

This block keeps the queueing state for a small set of CAN transmit slots (three by default) and decides which one goes on the bus next. Host software configures each slot through a single write port. The configuration is a 2-bit priority, an interrupt enable and a request flag. A slot with its request flag set is waiting to be sent. The scheduler does not store frames and does not drive the bus. When the bus-side logic reports that the bus is free, the scheduler picks the best waiting slot and gives its index to a protocol engine with a one-cycle start pulse. The engine then answers with exactly one outcome strobe: done, arbitration lost or error.

The outcome updates the status flags of the slot that was in flight. On success the request is retired. On lost arbitration or an error the request stays set, so the slot competes again at the next free-bus decision. The exception is an abort that arrived while the frame was in flight: in that case the slot is retired and marked as aborted.

Aborts come from two sources. Host software can clear a single slot's request, or it can pulse a global abort that covers every waiting slot. A slot that is not yet on the bus is aborted immediately. The slot on the bus finishes its frame, and the outcome then decides whether the abort takes effect.

Top module: `can_tx_sched`

## Requirements
- R1: After reset, every slot flag, the priorities, the enables, `busy_o`, `tx_start`, `err_int_o`, `irq_o` and `abort_all_busy_o` are all zero.
- R2: The slot chosen at a start has the highest priority among the waiting slots. Priority 2'b11 is highest and 2'b00 is lowest. Between equal priorities, the higher slot index wins.
- R3: A start happens only on a clock edge where `bus_idle` is high, no frame is in flight and at least one slot is waiting. `tx_start` rises for one cycle after that edge, with `tx_slot` naming the slot, and `busy_o` stays high until the outcome.
- R4: A write that sets an idle slot's request clears that slot's done, aborted, arbitration-lost and error flags.
- R5: A done outcome clears the in-flight slot's request and sets its done flag. `irq_o` is high while any slot has both its done flag and its interrupt enable set.
- R6: A lost-arbitration outcome sets the slot's arbitration-lost flag and leaves its request set, and the slot is chosen again at a later start.
- R7: An error outcome sets the slot's error flag and the shared error-interrupt flag `err_int_o`, which also raises `irq_o`, and leaves the request set. A pulse on `err_int_clr` clears `err_int_o`.
- R8: A host write with `wr_req` low to a waiting slot that is not in flight clears its request and sets its aborted flag on that edge.
- R9: An abort of the in-flight slot leaves its request set until the outcome. A done outcome then leaves the aborted flag clear. A lost-arbitration or error outcome clears the request and sets the aborted flag.
- R10: A host write to a slot whose request is set does not change that slot's priority or interrupt enable.
- R11: A global abort pulse aborts every waiting slot that is not in flight on that edge. If a frame is in flight, `abort_all_busy_o` stays high until that frame's outcome, and the in-flight slot then resolves as in R9.
- R12: The choice of slot is fixed at the start. Requests set or changed during a frame do not alter `tx_slot` and take part only in the next decision.
- R13: No start is made on an edge where `wr_en` or `abort_all` is high. The decision moves to the next free-bus edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_idle | input | 1 | Bus-side strobe: a frame may start now |
| wr_en | input | 1 | Host slot write strobe |
| wr_slot | input | IDX_W | Slot index being written |
| wr_req | input | 1 | Request value written (0 on a waiting slot = abort) |
| wr_prio | input | PRIO_W | Priority written |
| wr_ie | input | 1 | Interrupt enable written |
| abort_all | input | 1 | Global abort pulse |
| err_int_clr | input | 1 | Clears the shared error-interrupt flag |
| eng_done | input | 1 | Engine outcome: frame sent |
| eng_arb_lost | input | 1 | Engine outcome: arbitration lost |
| eng_error | input | 1 | Engine outcome: error during frame |
| tx_start | output | 1 | One-cycle start pulse to the engine |
| tx_slot | output | IDX_W | Index of the slot in flight |
| busy_o | output | 1 | A frame is in flight |
| req_o | output | NUM_SLOTS | Request flag per slot |
| prio_o | output | NUM_SLOTS*PRIO_W | Priority per slot, slot 0 in the low bits |
| ie_o | output | NUM_SLOTS | Interrupt enable per slot |
| done_o | output | NUM_SLOTS | Done flag per slot |
| abt_o | output | NUM_SLOTS | Aborted flag per slot |
| arbl_o | output | NUM_SLOTS | Arbitration-lost flag per slot |
| err_o | output | NUM_SLOTS | Error flag per slot |
| err_int_o | output | 1 | Shared error-interrupt flag |
| irq_o | output | 1 | Interrupt request |
| abort_all_busy_o | output | 1 | Global abort waiting on the in-flight frame |

## Verification
The properties assume the engine behaves as agreed. Outcome strobes arrive only while `busy_o` is high, and only one strobe is raised in any cycle. They also assume a single outcome per frame, so the slot named by `tx_slot` is still the slot in flight on the cycle after its outcome. The stimulus follows these rules throughout. It raises exactly one strobe per start, raises it only after `tx_start` has been seen, and lowers it again after one cycle. It also keeps `bus_idle` low while a frame is in flight, so that it cannot mask anything.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

   typedef enum logic [1:0] {
      OUT_NONE = 2'd0,
      OUT_DONE = 2'd1,
      OUT_ARB  = 2'd2,
      OUT_ERR  = 2'd3
   } tx_outcome_e;

   typedef struct packed {
      logic req;
      logic done;
      logic abt;
      logic arbl;
      logic err;
   } slot_flags_t;

endpackage

// File: rtl/can_tx_pick.sv
module can_tx_pick #(
   parameter int NUM_SLOTS = 3,
   parameter int PRIO_W    = 2,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS-1:0]        req,
   input  logic [NUM_SLOTS*PRIO_W-1:0] prio,
   output logic                        any,
   output logic [IDX_W-1:0]            win
);

   logic [PRIO_W-1:0] best;

   // Ascending scan with >= so a later (higher) index takes equal priority.
   always_comb begin
      any  = 1'b0;
      best = '0;
      win  = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (req[i] && (!any || prio[i*PRIO_W +: PRIO_W] >= best)) begin
            any  = 1'b1;
            best = prio[i*PRIO_W +: PRIO_W];
            win  = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/can_tx_slot.sv
module can_tx_slot
   import can_tx_pkg::*;
#(
   parameter int PRIO_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic              wr_req,
   input  logic [PRIO_W-1:0] wr_prio,
   input  logic              wr_ie,
   input  logic              abort_all,
   input  logic              active,
   input  tx_outcome_e       outcome,
   output slot_flags_t       flags,
   output logic [PRIO_W-1:0] prio,
   output logic              ie
);

   logic abort_pend;
   logic abort_now;
   logic resolve;

   assign abort_now = flags.req && ((wr_hit && !wr_req) || abort_all);
   assign resolve   = active && (outcome != OUT_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags      <= '0;
         prio       <= '0;
         ie         <= 1'b0;
         abort_pend <= 1'b0;
      end else if (resolve) begin
         abort_pend <= 1'b0;
         unique case (outcome)
            OUT_DONE: begin
               flags.req  <= 1'b0;
               flags.done <= 1'b1;
            end
            OUT_ARB, OUT_ERR: begin
               if (outcome == OUT_ARB) flags.arbl <= 1'b1;
               else                    flags.err  <= 1'b1;
               if (abort_pend || abort_now) begin
                  flags.req <= 1'b0;
                  flags.abt <= 1'b1;
               end
            end
            default: ;
         endcase
      end else if (abort_now) begin
         if (active) begin
            abort_pend <= 1'b1;
         end else begin
            flags.req <= 1'b0;
            flags.abt <= 1'b1;
         end
      end else if (wr_hit && !flags.req) begin
         prio <= wr_prio;
         ie   <= wr_ie;
         if (wr_req) begin
            flags.req  <= 1'b1;
            flags.done <= 1'b0;
            flags.abt  <= 1'b0;
            flags.arbl <= 1'b0;
            flags.err  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/can_tx_ctl.sv
module can_tx_ctl
   import can_tx_pkg::*;
#(
   parameter int NUM_SLOTS = 3,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_idle,
   input  logic             any_pend,
   input  logic [IDX_W-1:0] win,
   input  logic             hold,
   input  logic             abort_all,
   input  logic             eng_done,
   input  logic             eng_arb_lost,
   input  logic             eng_error,
   output logic             busy,
   output logic [IDX_W-1:0] act,
   output logic             start,
   output tx_outcome_e      outcome,
   output logic             abort_all_busy
);

   logic launch;

   always_comb begin
      outcome = OUT_NONE;
      if (busy) begin
         if (eng_done)          outcome = OUT_DONE;
         else if (eng_error)    outcome = OUT_ERR;
         else if (eng_arb_lost) outcome = OUT_ARB;
      end
   end

   assign launch = !busy && bus_idle && any_pend && !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy           <= 1'b0;
         act            <= '0;
         start          <= 1'b0;
         abort_all_busy <= 1'b0;
      end else begin
         start <= launch;
         if (outcome != OUT_NONE) begin
            busy           <= 1'b0;
            abort_all_busy <= 1'b0;
         end else begin
            if (launch) begin
               busy <= 1'b1;
               act  <= win;
            end
            if (abort_all && busy) abort_all_busy <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
   import can_tx_pkg::*;
#(
   parameter int NUM_SLOTS = 3,
   parameter int PRIO_W    = 2,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_idle,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_slot,
   input  logic                        wr_req,
   input  logic [PRIO_W-1:0]           wr_prio,
   input  logic                        wr_ie,
   input  logic                        abort_all,
   input  logic                        err_int_clr,
   input  logic                        eng_done,
   input  logic                        eng_arb_lost,
   input  logic                        eng_error,
   output logic                        tx_start,
   output logic [IDX_W-1:0]            tx_slot,
   output logic                        busy_o,
   output logic [NUM_SLOTS-1:0]        req_o,
   output logic [NUM_SLOTS*PRIO_W-1:0] prio_o,
   output logic [NUM_SLOTS-1:0]        ie_o,
   output logic [NUM_SLOTS-1:0]        done_o,
   output logic [NUM_SLOTS-1:0]        abt_o,
   output logic [NUM_SLOTS-1:0]        arbl_o,
   output logic [NUM_SLOTS-1:0]        err_o,
   output logic                        err_int_o,
   output logic                        irq_o,
   output logic                        abort_all_busy_o
);

   generate
      if (NUM_SLOTS < 2 || NUM_SLOTS > 32) begin : g_bad_slots
         $error("can_tx_sched: NUM_SLOTS must be 2..32");
      end
      if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
         $error("can_tx_sched: PRIO_W must be 1..8");
      end
   endgenerate

   logic             any_pend;
   logic [IDX_W-1:0] win;
   tx_outcome_e      outcome;
   logic             err_int;

   can_tx_pick #(.NUM_SLOTS(NUM_SLOTS), .PRIO_W(PRIO_W)) u_pick (
      .req  (req_o),
      .prio (prio_o),
      .any  (any_pend),
      .win  (win)
   );

   can_tx_ctl #(.NUM_SLOTS(NUM_SLOTS)) u_ctl (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_idle       (bus_idle),
      .any_pend       (any_pend),
      .win            (win),
      .hold           (wr_en | abort_all),
      .abort_all      (abort_all),
      .eng_done       (eng_done),
      .eng_arb_lost   (eng_arb_lost),
      .eng_error      (eng_error),
      .busy           (busy_o),
      .act            (tx_slot),
      .start          (tx_start),
      .outcome        (outcome),
      .abort_all_busy (abort_all_busy_o)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      slot_flags_t fl;
      can_tx_slot #(.PRIO_W(PRIO_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_hit    (wr_en && (wr_slot == IDX_W'(i))),
         .wr_req    (wr_req),
         .wr_prio   (wr_prio),
         .wr_ie     (wr_ie),
         .abort_all (abort_all),
         .active    (busy_o && (tx_slot == IDX_W'(i))),
         .outcome   (outcome),
         .flags     (fl),
         .prio      (prio_o[i*PRIO_W +: PRIO_W]),
         .ie        (ie_o[i])
      );
      assign req_o[i]  = fl.req;
      assign done_o[i] = fl.done;
      assign abt_o[i]  = fl.abt;
      assign arbl_o[i] = fl.arbl;
      assign err_o[i]  = fl.err;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  err_int <= 1'b0;
      else if (outcome == OUT_ERR) err_int <= 1'b1;
      else if (err_int_clr)        err_int <= 1'b0;
   end

   assign err_int_o = err_int;
   assign irq_o     = (|(done_o & ie_o)) | err_int;

endmodule

// File: rtl/can_tx_sched_chk.sv
module can_tx_sched_chk #(
   parameter int NUM_SLOTS = 3,
   parameter int PRIO_W    = 2,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_idle,
   input logic                        eng_done,
   input logic                        eng_arb_lost,
   input logic                        eng_error,
   input logic                        tx_start,
   input logic [IDX_W-1:0]            tx_slot,
   input logic                        busy_o,
   input logic [NUM_SLOTS-1:0]        req_o,
   input logic [NUM_SLOTS*PRIO_W-1:0] prio_o,
   input logic [NUM_SLOTS-1:0]        done_o,
   input logic [NUM_SLOTS-1:0]        abt_o,
   input logic [NUM_SLOTS-1:0]        arbl_o,
   input logic [NUM_SLOTS-1:0]        err_o,
   input logic                        err_int_o,
   input logic                        abort_all_busy_o
);

   logic [NUM_SLOTS-1:0]        req_q;
   logic [NUM_SLOTS*PRIO_W-1:0] prio_q;
   logic                        bad_pick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         prio_q <= '0;
      end else begin
         req_q  <= req_o;
         prio_q <= prio_o;
      end
   end

   always_comb begin
      bad_pick = !req_q[tx_slot];
      for (int j = 0; j < NUM_SLOTS; j++) begin
         if (req_q[j] && IDX_W'(j) != tx_slot &&
             (prio_q[j*PRIO_W +: PRIO_W] > prio_q[tx_slot*PRIO_W +: PRIO_W] ||
              (prio_q[j*PRIO_W +: PRIO_W] == prio_q[tx_slot*PRIO_W +: PRIO_W] &&
               IDX_W'(j) > tx_slot)))
            bad_pick = 1'b1;
      end
   end

   AST_OUTCOME_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done || eng_arb_lost || eng_error) |-> busy_o); // R3
   AST_START_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> $past(bus_idle)); // R3
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start); // R3
   AST_PICK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> !bad_pick); // R2
   AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && eng_done) |=> (!req_o[tx_slot] && done_o[tx_slot])); // R5
   AST_ARB_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && eng_arb_lost && !eng_done && !eng_error) |=> arbl_o[tx_slot]); // R6
   AST_ERR_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && eng_error && !eng_done) |=> (err_int_o && err_o[tx_slot])); // R7
   AST_ABORT_ALL_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      abort_all_busy_o |-> busy_o); // R11

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_rise
      AST_REQ_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(req_o[i]) |-> !(done_o[i] || abt_o[i] || arbl_o[i] || err_o[i])); // R4
   end

endmodule

bind can_tx_sched can_tx_sched_chk #(.NUM_SLOTS(NUM_SLOTS), .PRIO_W(PRIO_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .bus_idle         (bus_idle),
   .eng_done         (eng_done),
   .eng_arb_lost     (eng_arb_lost),
   .eng_error        (eng_error),
   .tx_start         (tx_start),
   .tx_slot          (tx_slot),
   .busy_o           (busy_o),
   .req_o            (req_o),
   .prio_o           (prio_o),
   .done_o           (done_o),
   .abt_o            (abt_o),
   .arbl_o           (arbl_o),
   .err_o            (err_o),
   .err_int_o        (err_int_o),
   .abort_all_busy_o (abort_all_busy_o)
);

// File: tb/can_tx_sched_test.sv
module can_tx_sched_test;

   localparam int N  = 3;
   localparam int PW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_idle = 0, wr_en = 0, wr_req = 0, wr_ie = 0, abort_all = 0, err_int_clr = 0;
   logic [1:0] wr_slot = '0;
   logic [PW-1:0] wr_prio = '0;
   logic eng_done = 0, eng_arb_lost = 0, eng_error = 0;
   logic tx_start, busy_o, err_int_o, irq_o, abort_all_busy_o;
   logic [1:0] tx_slot;
   logic [N-1:0] req_o, ie_o, done_o, abt_o, arbl_o, err_o;
   logic [N*PW-1:0] prio_o;

   int n_chk = 0;
   int n_fail = 0;
   bit model_ok = 0;

   always #2 clk = ~clk;

   can_tx_sched #(.NUM_SLOTS(N), .PRIO_W(PW)) uut (.*);

   // Behavioural reference model
   int m_req[N], m_prio[N], m_ie[N], m_done[N], m_abt[N], m_arbl[N], m_err[N], m_ap[N];
   int m_busy, m_act, m_start, m_aa, m_eint;
   int oc, best, launch, hit, kill, wr_here;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < N; s++) begin
            m_req[s] = 0; m_prio[s] = 0; m_ie[s] = 0; m_done[s] = 0;
            m_abt[s] = 0; m_arbl[s] = 0; m_err[s] = 0; m_ap[s] = 0;
         end
         m_busy = 0; m_act = 0; m_start = 0; m_aa = 0; m_eint = 0;
         model_ok = 1;
      end else begin
         oc = 0;
         if (m_busy != 0) oc = eng_done ? 1 : eng_error ? 3 : eng_arb_lost ? 2 : 0;
         best = -1;
         for (int s = N - 1; s >= 0; s--)
            if (m_req[s] != 0 && (best < 0 || m_prio[s] > m_prio[best])) best = s;
         launch = (m_busy == 0 && bus_idle && !wr_en && !abort_all && best >= 0) ? 1 : 0;
         for (int s = 0; s < N; s++) begin
            hit = (m_busy != 0 && m_act == s) ? 1 : 0;
            wr_here = (wr_en && wr_slot == 2'(s)) ? 1 : 0;
            kill = (m_req[s] != 0 && ((wr_here != 0 && !wr_req) || abort_all)) ? 1 : 0;
            if (hit != 0 && oc != 0) begin
               if (oc == 1) begin m_req[s] = 0; m_done[s] = 1; end
               else begin
                  if (oc == 2) m_arbl[s] = 1; else m_err[s] = 1;
                  if (m_ap[s] != 0 || kill != 0) begin m_req[s] = 0; m_abt[s] = 1; end
               end
               m_ap[s] = 0;
            end else if (kill != 0) begin
               if (hit != 0) m_ap[s] = 1;
               else begin m_req[s] = 0; m_abt[s] = 1; end
            end else if (wr_here != 0 && m_req[s] == 0) begin
               m_prio[s] = int'(wr_prio); m_ie[s] = int'(wr_ie);
               if (wr_req) begin
                  m_req[s] = 1; m_done[s] = 0; m_abt[s] = 0; m_arbl[s] = 0; m_err[s] = 0;
               end
            end
         end
         if (oc == 3) m_eint = 1; else if (err_int_clr) m_eint = 0;
         if (oc != 0) begin m_aa = 0; m_busy = 0; end
         else begin
            if (abort_all && m_busy != 0) m_aa = 1;
            if (launch != 0) begin m_busy = 1; m_act = best; end
         end
         m_start = launch;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && model_ok) begin
         int irq_m;
         irq_m = m_eint;
         chk("R3 tx_start", int'(tx_start), m_start);
         chk("R3 busy", int'(busy_o), m_busy);
         if (m_busy != 0) chk("R2 tx_slot", int'(tx_slot), m_act);
         chk("R7 err_int", int'(err_int_o), m_eint);
         chk("R11 abort_all_busy", int'(abort_all_busy_o), m_aa);
         for (int s = 0; s < N; s++) begin
            if (m_done[s] != 0 && m_ie[s] != 0) irq_m = 1;
            chk("R6 req", int'(req_o[s]), m_req[s]);
            chk("R5 done", int'(done_o[s]), m_done[s]);
            chk("R9 abt", int'(abt_o[s]), m_abt[s]);
            chk("R6 arbl", int'(arbl_o[s]), m_arbl[s]);
            chk("R7 err", int'(err_o[s]), m_err[s]);
            chk("R10 prio", int'(prio_o[s*PW +: PW]), m_prio[s]);
            chk("R10 ie", int'(ie_o[s]), m_ie[s]);
         end
         chk("R5 irq", int'(irq_o), irq_m);
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic hwrite(int s, bit rq, int p, bit ie);
      wr_en = 1; wr_slot = 2'(s); wr_req = rq; wr_prio = PW'(p); wr_ie = ie;
      tick();
      wr_en = 0; wr_req = 0;
   endtask

   task automatic go(int exp_slot);
      bus_idle = 1;
      tick();
      bus_idle = 0;
      chk("R3 start pulse", int'(tx_start), 1);
      chk("R2 chosen slot", int'(tx_slot), exp_slot);
   endtask

   task automatic outc(int kind);
      eng_done = (kind == 1); eng_arb_lost = (kind == 2); eng_error = (kind == 3);
      tick();
      eng_done = 0; eng_arb_lost = 0; eng_error = 0;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R3 watchdog expired actual=1 expected=0");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 req", int'(req_o), 0);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 irq", int'(irq_o), 0);

      hwrite(0, 1, 1, 1);
      hwrite(1, 1, 2, 0);
      hwrite(2, 1, 2, 1);
      tick(); tick();
      chk("R3 no start without bus idle", int'(busy_o), 0);
      go(2);                          // R2 tie goes to slot 2
      outc(1);
      chk("R5 req cleared", int'(req_o[2]), 0);
      chk("R5 done set", int'(done_o[2]), 1);
      chk("R5 irq", int'(irq_o), 1);
      go(1);
      outc(2);
      chk("R6 arbl set", int'(arbl_o[1]), 1);
      chk("R6 still pending", int'(req_o[1]), 1);
      go(1);                          // R6 retry
      outc(3);
      chk("R7 err flag", int'(err_o[1]), 1);
      chk("R7 err_int", int'(err_int_o), 1);
      err_int_clr = 1; tick(); err_int_clr = 0;
      chk("R7 err_int cleared", int'(err_int_o), 0);
      go(1);
      hwrite(0, 1, 3, 0);
      chk("R10 prio kept", int'(prio_o[1:0]), 1);
      chk("R10 ie kept", int'(ie_o[0]), 1);
      outc(1);
      go(0);
      hwrite(2, 1, 3, 1);
      chk("R4 done cleared on request", int'(done_o[2]), 0);
      chk("R12 slot unchanged", int'(tx_slot), 0);
      outc(1);
      go(2);
      outc(1);

      // R8 abort of a waiting slot
      hwrite(0, 1, 1, 0);
      hwrite(0, 0, 1, 0);
      chk("R8 req cleared", int'(req_o[0]), 0);
      chk("R8 abt set", int'(abt_o[0]), 1);
      hwrite(0, 1, 1, 0);
      chk("R4 abt cleared", int'(abt_o[0]), 0);
      // R9 abort during a frame that completes
      go(0);
      hwrite(0, 0, 1, 0);
      chk("R9 req held in flight", int'(req_o[0]), 1);
      outc(1);
      chk("R9 abt clear after done", int'(abt_o[0]), 0);
      chk("R9 done after abort", int'(done_o[0]), 1);
      // R9 abort during a frame that loses arbitration
      hwrite(1, 1, 2, 0);
      go(1);
      hwrite(1, 0, 2, 0);
      outc(2);
      chk("R9 req cleared after arb", int'(req_o[1]), 0);
      chk("R9 abt after arb", int'(abt_o[1]), 1);

      // R11 global abort
      hwrite(0, 1, 0, 0);
      hwrite(1, 1, 1, 0);
      hwrite(2, 1, 3, 0);
      go(2);
      abort_all = 1; tick(); abort_all = 0;
      chk("R11 waiting slots aborted", int'(req_o), 4);
      chk("R11 abt flags", int'(abt_o[1:0]), 3);
      chk("R11 held", int'(abort_all_busy_o), 1);
      outc(3);
      chk("R11 in-flight aborted", int'(abt_o[2]), 1);
      chk("R11 released", int'(abort_all_busy_o), 0);

      // R13 start held off by a host write
      hwrite(0, 1, 0, 0);
      bus_idle = 1;
      hwrite(1, 1, 1, 0);
      chk("R13 no start during write", int'(tx_start), 0);
      tick();
      bus_idle = 0;
      chk("R13 start next edge", int'(tx_start), 1);
      chk("R2 higher prio slot", int'(tx_slot), 1);
      outc(1);
      go(0);
      outc(1);
      tick();
      report();
   end

endmodule